// File: doc/BRIEF.md
# Decimal Carry-Chain Adder

This block adds two packed decimal numbers of `DIGITS` BCD digits each, plus a one-bit incoming carry. It returns a BCD sum of the same width and a decimal carry-out. The block is purely combinational and has no clock or reset. It is meant to sit inside a datapath that already holds valid BCD operands.

Each digit position works out two flags straight from the operand bits, not from a binary sum. The first flag says the digit pair passes an incoming carry through. The second says the pair makes a carry whatever comes in. The carries between digits then pass through one 2-to-1 select per digit, so the path that grows with width is a chain of multiplexers. Each digit result comes from a 4-bit binary add of the two digits and the carry into that digit. When a decimal carry leaves the digit, 6 is added to the upper three bits of that binary result. The lowest bit passes through unchanged.

Top module: `bcd_chain_adder`

## Requirements
- R1: For valid BCD operands, `sum_o` equals (A + B + `cin_i`) modulo 10^DIGITS as packed BCD. Digit k sits in bits [4k+3:4k], and every result digit is in the range 0..9.
- R2: `cout_o` is 1 exactly when A + B + `cin_i` is 10^DIGITS or more.
- R3: `cin_i` enters the least significant digit as a carry of weight 1. For example, all-9s plus 0 with `cin_i`=1 gives a sum of all 0s and `cout_o`=1.
- R4: A digit whose two operand digits add to more than 9 passes a carry to the next digit, whatever carry it receives.
- R5: A digit whose two operand digits add to exactly 9 passes its incoming carry on unchanged, across any run of such digits. No digit both passes and generates a carry.
- R6: A digit whose two operand digits add to less than 9 stops the carry: the next digit receives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*DIGITS | First operand, packed BCD |
| b_i | input | 4*DIGITS | Second operand, packed BCD |
| cin_i | input | 1 | Incoming carry into the lowest digit |
| sum_o | output | 4*DIGITS | Packed BCD sum |
| cout_o | output | 1 | Decimal carry out of the top digit |

## Verification
Two effects can meet in one evaluation: a carry that a low digit generates, and a run of digits that pass it on. These combine into a single ripple through every mux stage. Operands such as 4545 + 5454, and 9999 + 0000 with a carry-in, make one event travel the whole chain. The bench judges the result by comparing the integer value of the BCD sum and the carry-out with plain integer addition. Random valid-BCD operands mix generating, passing and stopping digits in the same addition.

// File: rtl/bcd_chain_pkg.sv
package bcd_chain_pkg;

  typedef struct packed {
    logic p;  // pair passes an incoming carry
    logic g;  // pair produces a carry by itself
  } dpg_t;

  // Flags from operand bits: the upper three bits of each digit carry weights 2,4,8.
  function automatic dpg_t digit_pg(input logic [3:0] a, input logic [3:0] b);
    dpg_t r;
    logic [3:0] hs;
    hs  = {1'b0, a[3:1]} + {1'b0, b[3:1]};
    r.p = (hs == 4'd4) && (a[0] ^ b[0]);
    r.g = (hs >= 4'd5) || ((hs == 4'd4) && a[0] && b[0]);
    return r;
  endfunction

  // Low four bits of the binary digit sum.
  function automatic logic [3:0] digit_bin(input logic [3:0] a, input logic [3:0] b,
                                           input logic ci);
    return a + b + {3'b000, ci};
  endfunction

  // Add six through the upper three bits when a decimal carry leaves the digit.
  function automatic logic [3:0] digit_fix(input logic [3:0] bin, input logic dc);
    logic [2:0] hi;
    hi = bin[3:1] + 3'd3;
    return dc ? {hi, bin[0]} : bin;
  endfunction

endpackage

// File: rtl/bcd_pg_cell.sv
module bcd_pg_cell
  import bcd_chain_pkg::*;
(
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  output logic       p_o,
  output logic       g_o
);
  dpg_t pg;
  always_comb begin
    pg  = digit_pg(a_i, b_i);
    p_o = pg.p;
    g_o = pg.g;
  end
endmodule

// File: rtl/bcd_carry_chain.sv
module bcd_carry_chain #(
  parameter int DIGITS = 4
) (
  input  logic [DIGITS-1:0] p_i,
  input  logic [DIGITS-1:0] g_i,
  input  logic              cin_i,
  output logic [DIGITS:0]   carry_o
);
  assign carry_o[0] = cin_i;
  for (genvar i = 0; i < DIGITS; i++) begin : g_stage
    // one 2-to-1 select per digit
    assign carry_o[i+1] = p_i[i] ? carry_o[i] : g_i[i];
  end
endmodule

// File: rtl/bcd_digit_sum.sv
module bcd_digit_sum
  import bcd_chain_pkg::*;
(
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       ci_i,
  input  logic       co_i,
  output logic [3:0] s_o
);
  logic [3:0] bin;
  always_comb begin
    bin = digit_bin(a_i, b_i, ci_i);
    s_o = digit_fix(bin, co_i);
  end
endmodule

// File: rtl/bcd_chain_adder.sv
module bcd_chain_adder #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] a_i,
  input  logic [4*DIGITS-1:0] b_i,
  input  logic                cin_i,
  output logic [4*DIGITS-1:0] sum_o,
  output logic                cout_o
);
  localparam int W = 4 * DIGITS;

  logic [DIGITS-1:0] dig_p;
  logic [DIGITS-1:0] dig_g;
  logic [DIGITS:0]   dig_c;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    bcd_pg_cell u_pg (
      .a_i (a_i[4*i +: 4]),
      .b_i (b_i[4*i +: 4]),
      .p_o (dig_p[i]),
      .g_o (dig_g[i])
    );
    bcd_digit_sum u_sum (
      .a_i  (a_i[4*i +: 4]),
      .b_i  (b_i[4*i +: 4]),
      .ci_i (dig_c[i]),
      .co_i (dig_c[i+1]),
      .s_o  (sum_o[4*i +: 4])
    );
  end

  bcd_carry_chain #(.DIGITS(DIGITS)) u_chain (
    .p_i     (dig_p),
    .g_i     (dig_g),
    .cin_i   (cin_i),
    .carry_o (dig_c)
  );

  assign cout_o = dig_c[DIGITS];

  logic [W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/bcd_chain_adder_chk.sv
module bcd_chain_adder_chk #(
  parameter int DIGITS = 4
) (
  input logic [4*DIGITS-1:0] a_i,
  input logic [4*DIGITS-1:0] b_i,
  input logic                cin_i,
  input logic [4*DIGITS-1:0] sum_o,
  input logic                cout_o,
  input logic [DIGITS-1:0]   dig_p,
  input logic [DIGITS-1:0]   dig_g,
  input logic [DIGITS:0]     dig_c
);
  function automatic logic all_bcd(input logic [4*DIGITS-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++) if (v[4*k +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  function automatic longint to_int(input logic [4*DIGITS-1:0] v);
    longint r;
    r = 0;
    for (int k = DIGITS - 1; k >= 0; k--) r = r * 10 + longint'(v[4*k +: 4]);
    return r;
  endfunction

  function automatic longint ten_pow();
    longint r;
    r = 1;
    for (int k = 0; k < DIGITS; k++) r = r * 10;
    return r;
  endfunction

  logic   valid;
  longint total;

  always_comb begin
    valid = all_bcd(a_i) && all_bcd(b_i);
    total = to_int(a_i) + to_int(b_i) + longint'(cin_i);
    if (valid) begin
      // R1
      digit_range_chk: assert (all_bcd(sum_o));
      // R2
      carry_out_chk: assert (cout_o == (total >= ten_pow()));
      for (int i = 0; i < DIGITS; i++) begin
        // R5
        pg_excl_chk: assert (!(dig_p[i] && dig_g[i]));
        // R5
        prop_nine_chk: assert (!dig_p[i] || (a_i[4*i +: 4] + b_i[4*i +: 4] == 4'd9));
        // R4
        gen_carry_chk: assert (!dig_g[i] || dig_c[i+1]);
        // R6
        kill_carry_chk: assert (({1'b0, a_i[4*i +: 4]} + {1'b0, b_i[4*i +: 4]} >= 5'd9)
                                || !dig_c[i+1]);
      end
    end
  end
endmodule

bind bcd_chain_adder bcd_chain_adder_chk #(.DIGITS(DIGITS)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .dig_p  (dig_p),
  .dig_g  (dig_g),
  .dig_c  (dig_c)
);

// File: tb/bcd_chain_adder_tb.sv
`timescale 1ns/1ps
module bcd_chain_adder_tb;
  localparam int DIGITS = 4;
  localparam int W = 4 * DIGITS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, s;
  logic         ci, co;
  int total_n = 0;
  int bad_n = 0;
  bit finished = 0;

  bcd_chain_adder #(.DIGITS(DIGITS)) u_dut (
    .a_i(a), .b_i(b), .cin_i(ci), .sum_o(s), .cout_o(co)
  );

  typedef struct packed {
    logic [7:0]   req;
    logic [15:0]  va;
    logic [15:0]  vb;
    logic         vci;
    logic [15:0]  vs;
    logic         vco;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},  // R1 zeros
    '{8'd1, 16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0},  // R1 no carries
    '{8'd3, 16'h9999, 16'h0000, 1'b1, 16'h0000, 1'b1},  // R3 carry-in ripples all
    '{8'd4, 16'h0005, 16'h0005, 1'b0, 16'h0010, 1'b0},  // R4 generate
    '{8'd5, 16'h4545, 16'h5454, 1'b1, 16'h0000, 1'b1},  // R5 full pass
    '{8'd5, 16'h4545, 16'h5454, 1'b0, 16'h9999, 1'b0},  // R5 pass of zero
    '{8'd6, 16'h0000, 16'h0999, 1'b1, 16'h1000, 1'b0},  // R6 stop at top
    '{8'd2, 16'h9999, 16'h9999, 1'b1, 16'h9999, 1'b1},  // R2 maximum
    '{8'd2, 16'h5000, 16'h5000, 1'b0, 16'h0000, 1'b1},  // R2 top digit carry
    '{8'd5, 16'h0008, 16'h0001, 1'b1, 16'h0010, 1'b0}   // R5 single pass
  };

  function automatic int to_int(input logic [W-1:0] v);
    int r = 0;
    for (int k = DIGITS - 1; k >= 0; k--) r = r * 10 + int'(v[4*k +: 4]);
    return r;
  endfunction

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r;
    int x = v;
    for (int k = 0; k < DIGITS; k++) begin
      r[4*k +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] es, input logic eco);
    total_n++;
    if (s !== es || co !== eco) begin
      bad_n++;
      $display("FAIL %s a=%h b=%h ci=%0b: got sum=%h cout=%0b, expected sum=%h cout=%0b",
               tag, a, b, ci, s, co, es, eco);
    end
  endtask

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vci);
    @(negedge clk);
    a = va; b = vb; ci = vci;
    #2;
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0;
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].va, VECS[i].vb, VECS[i].vci);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].vs, VECS[i].vco);
    end
    // R4: generating digit carries regardless of incoming carry
    apply(16'h0097, 16'h0003, 1'b1);
    check("R4 gen with cin", 16'h0101, 1'b0);
    // R6: digit sum 8 stops a carry from below
    apply(16'h0035, 16'h0056, 1'b0);
    check("R6 stop mid", 16'h0091, 1'b0);
    // R1 and R2: random valid BCD against integer addition
    for (int n = 0; n < 400; n++) begin
      int ia, ib, ic, sm;
      ia = int'($urandom_range(0, 9999));
      ib = int'($urandom_range(0, 9999));
      ic = int'($urandom_range(0, 1));
      apply(to_bcd(ia), to_bcd(ib), ic[0]);
      sm = ia + ib + ic;
      check("R1/R2 random", to_bcd(sm % 10000), sm >= 10000);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total_n++;
      bad_n++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
    end
  end
endmodule